// File: doc/BRIEF.md
# Digital CPU Temperature Channel Status and Alert

This block watches four digital CPU-temperature channels. Each channel delivers a 16-bit reading with a one-cycle valid strobe, together with per-transaction flags that report a bad frame check sequence or a failed link transfer. The block keeps a programmable signed low limit and high limit per channel and compares every valid reading against them in the cycle it arrives. A small band of reserved codes at the bottom of the signed range is not a temperature: such a reading is flagged as a data error and skips the limit comparison.

Results are collected in sticky status bits, placed at fixed positions in two byte-wide status registers called A and B. A host reads either register through a simple read port. The read also clears the register that was read. A mask register pair, laid out bit for bit like the status registers, decides which status bits may pull the active-low alert output. The wire protocol that produces the readings is outside this block.

Top module: `cpu_temp_status`

## Requirements
- R1: After reset both status registers read 0x00, both mask registers are 0x00 and `alert_n` is high. Every low limit is 0x8000 and every high limit is 0x7FFF, so no reading can violate a limit.
- R2: A valid reading from 0x8000 to 0x8003 inclusive on any channel sets status A bit 1. It causes no limit violation for that sample. 0x8004 is an ordinary temperature.
- R3: A high `fcs_bad` or `link_fail` bit for any channel in a cycle sets status A bit 2. Both kinds of failure share that bit.
- R4: A limit violation on channel 0 sets status A bit 1'b0 position, that is bit 0.
- R5: Limit violations on channels 1, 2 and 3 set status B bits 3, 4 and 5. Status A bits 7:3 and status B bits 7:6 and 2:0 always read 0.
- R6: A valid reading violates a limit when, read as signed 16-bit values, it is strictly greater than the channel's high limit or strictly less than its low limit. A reading equal to a limit is not a violation.
- R7: Status bits are sticky. A cycle with `host_rd` high clears the register chosen by `host_sel` (0 = A, 1 = B) at the clock edge. An event in that same cycle sets its bit again, so the set wins.
- R8: `alert_n` is low exactly when some status bit is set whose mask bit, at the same position in the matching mask register, is 0. A write with `msk_we` high loads `msk_wdata` into mask A (`msk_sel`=0) or mask B (`msk_sel`=1).
- R9: A write with `lim_we` high loads `lim_wdata` into the limit of channel `lim_ch`: the high limit if `lim_hi_sel`=1, otherwise the low limit. It takes effect for readings from the next cycle on. A reading in the same cycle still uses the old limit.
- R10: A reading whose valid bit is low has no effect on any status bit.
- R11: `host_rdata` always shows the register selected by `host_sel`. Setting `host_sel` without `host_rd` clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 4 | Per-channel reading strobe |
| smp_data | input | 64 | Readings, channel n in bits 16n+15:16n |
| fcs_bad | input | 4 | Per-channel bad frame check flag |
| link_fail | input | 4 | Per-channel transfer failure flag |
| lim_we | input | 1 | Limit write enable |
| lim_ch | input | 2 | Channel of the limit write |
| lim_hi_sel | input | 1 | 1 writes high limit, 0 writes low limit |
| lim_wdata | input | 16 | Limit value (signed) |
| msk_we | input | 1 | Mask write enable |
| msk_sel | input | 1 | 0 selects mask A, 1 selects mask B |
| msk_wdata | input | 8 | Mask value |
| host_rd | input | 1 | Read strobe; clears the selected status register |
| host_sel | input | 1 | 0 selects status A, 1 selects status B |
| host_rdata | output | 8 | Selected status register |
| alert_n | output | 1 | Active-low alert |

## Verification
Each sample, flag, mask write or limit write is registered at exactly one clock edge. The status bits it sets, and the `alert_n` level that follows from them, can be seen from the next falling edge. A read strobe clears at that same edge. The bench drives one cycle of stimulus after a falling edge and updates its model at the rising edge. At the following falling edge it peeks at both registers by toggling `host_sel` with `host_rd` low, and checks them and `alert_n` against the model. Limit writes that happen together with a sample are modelled as applying after the comparison.

// File: rtl/cts_pkg.sv
// Package: shared constants for the temperature channel status block.
// Assumes byte-wide host registers and a fixed bit layout that a host
// driver decodes.
package cts_pkg;
    localparam int REG_W        = 8;
    // status/mask register A bit positions
    localparam int BIT_CH0_LIM  = 0;
    localparam int BIT_DATA_ERR = 1;
    localparam int BIT_XFER_ERR = 2;
    // status/mask register B: channel k (k>=1) uses bit CHB_BASE + k - 1
    localparam int CHB_BASE     = 3;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/cts_limit_regs.sv
// Module: cts_limit_regs
// Holds a signed low and high limit per channel. It assumes one write per
// cycle. After reset the limits are the extreme signed values, so no
// reading can violate them.
module cts_limit_regs #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CW-1:0]           wr_ch,
    input  logic                    wr_hi,
    input  logic [DW-1:0]           wr_data,
    output logic [NCH-1:0][DW-1:0]  lo_lim,
    output logic [NCH-1:0][DW-1:0]  hi_lim
);
    localparam logic [DW-1:0] LO_RST = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] HI_RST = {1'b0, {(DW-1){1'b1}}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Purpose: load the addressed limit of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_lim[c] <= LO_RST;
                hi_lim[c] <= HI_RST;
            end else if (wr_en && (wr_ch == CW'(c))) begin
                if (wr_hi) hi_lim[c] <= wr_data;
                else       lo_lim[c] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cts_chan_eval.sv
// Module: cts_chan_eval
// Classifies one channel's reading. It either falls in the reserved
// error-code band or, as a signed value, lies outside [lo, hi]. The module is
// purely combinational and assumes the limits are stable during the cycle.
module cts_chan_eval #(
    parameter int DW       = 16,
    parameter int ERR_SPAN = 4
) (
    input  logic          vld,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic          data_err,
    output logic          lim_viol
);
    localparam logic [DW-1:0] ERR_LO = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] ERR_HI = ERR_LO + DW'(ERR_SPAN - 1);

    logic in_band;
    logic outside;

    // Purpose: detect the reserved band and the signed window violation.
    always_comb begin
        in_band  = (data >= ERR_LO) && (data <= ERR_HI);
        outside  = ($signed(data) > $signed(hi)) || ($signed(data) < $signed(lo));
        data_err = vld && in_band;
        lim_viol = vld && !in_band && outside;
    end
endmodule

// File: rtl/cts_status_regs.sv
// Module: cts_status_regs
// Sticky status registers A and B, their masks and the alert output. It
// assumes at most NCH-1 channels map into register B. On the same edge a
// set beats a clear-on-read.
module cts_status_regs
    import cts_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    viol,
    input  logic              any_data_err,
    input  logic              any_xfer_err,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic              msk_en,
    input  logic              msk_sel,
    input  logic [REG_W-1:0]  msk_data,
    output logic [REG_W-1:0]  stat_a,
    output logic [REG_W-1:0]  stat_b,
    output logic              alert_n
);
    logic [REG_W-1:0] set_a, set_b, clr_a, clr_b;
    logic [REG_W-1:0] mask_a, mask_b;

    // Purpose: route event sources to their fixed bit positions.
    always_comb begin
        set_a = '0;
        set_b = '0;
        set_a[BIT_CH0_LIM]  = viol[0];
        set_a[BIT_DATA_ERR] = any_data_err;
        set_a[BIT_XFER_ERR] = any_xfer_err;
        for (int k = 1; k < NCH; k++) begin
            set_b[CHB_BASE + k - 1] = viol[k];
        end
        clr_a = {REG_W{rd_en && (rd_sel == SEL_A)}};
        clr_b = {REG_W{rd_en && (rd_sel == SEL_B)}};
    end

    // Purpose: sticky status update, clear-on-read with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a <= '0;
            stat_b <= '0;
        end else begin
            stat_a <= (stat_a & ~clr_a) | set_a;
            stat_b <= (stat_b & ~clr_b) | set_b;
        end
    end

    // Purpose: host-written alert masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else if (msk_en) begin
            if (msk_sel == SEL_B) mask_b <= msk_data;
            else                  mask_a <= msk_data;
        end
    end

    // Purpose: active-low alert from any unmasked sticky bit.
    always_comb begin
        alert_n = ~(|(stat_a & ~mask_a) | |(stat_b & ~mask_b));
    end
endmodule

// File: rtl/cpu_temp_status.sv
// Module: cpu_temp_status (top)
// Evaluates four temperature channels against signed limits and the reserved
// error band, collects sticky status and drives an active-low alert. It
// assumes the readings and flags are single-cycle and synchronous to clk.
module cpu_temp_status
    import cts_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int DW       = 16,
    parameter int ERR_SPAN = 4,
    localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      smp_valid,
    input  logic [NCH*DW-1:0]   smp_data,
    input  logic [NCH-1:0]      fcs_bad,
    input  logic [NCH-1:0]      link_fail,
    input  logic                lim_we,
    input  logic [CW-1:0]       lim_ch,
    input  logic                lim_hi_sel,
    input  logic [DW-1:0]       lim_wdata,
    input  logic                msk_we,
    input  logic                msk_sel,
    input  logic [REG_W-1:0]    msk_wdata,
    input  logic                host_rd,
    input  logic                host_sel,
    output logic [REG_W-1:0]    host_rdata,
    output logic                alert_n
);
    logic [NCH-1:0][DW-1:0] lo_lim, hi_lim;
    logic [NCH-1:0]         derr, viol;
    logic [REG_W-1:0]       stat_a, stat_b;
    logic                   any_derr, any_xerr;

    cts_limit_regs #(.NCH(NCH), .DW(DW)) u_lims (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lim_we),
        .wr_ch   (lim_ch),
        .wr_hi   (lim_hi_sel),
        .wr_data (lim_wdata),
        .lo_lim  (lo_lim),
        .hi_lim  (hi_lim)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_eval
        cts_chan_eval #(.DW(DW), .ERR_SPAN(ERR_SPAN)) u_eval (
            .vld      (smp_valid[c]),
            .data     (smp_data[c*DW +: DW]),
            .lo       (lo_lim[c]),
            .hi       (hi_lim[c]),
            .data_err (derr[c]),
            .lim_viol (viol[c])
        );
    end

    // Purpose: merge per-channel error sources into the shared bits.
    always_comb begin
        any_derr = |derr;
        any_xerr = |(fcs_bad | link_fail);
    end

    cts_status_regs #(.NCH(NCH)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .viol         (viol),
        .any_data_err (any_derr),
        .any_xfer_err (any_xerr),
        .rd_en        (host_rd),
        .rd_sel       (host_sel),
        .msk_en       (msk_we),
        .msk_sel      (msk_sel),
        .msk_data     (msk_wdata),
        .stat_a       (stat_a),
        .stat_b       (stat_b),
        .alert_n      (alert_n)
    );

    // Purpose: host read mux.
    always_comb begin
        host_rdata = (host_sel == SEL_B) ? stat_b : stat_a;
    end
endmodule

// File: rtl/cts_status_chk.sv
// Module: cts_status_chk
// Property checker bound into cpu_temp_status. It observes the ports and the
// two status registers.
module cts_status_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vld0,
    input logic [DW-1:0]   data0,
    input logic [NCH-1:0]  fcs_bad,
    input logic [NCH-1:0]  link_fail,
    input logic [NCH-1:0]  smp_valid,
    input logic            host_rd,
    input logic            host_sel,
    input logic            alert_n,
    input logic [7:0]      stat_a,
    input logic [7:0]      stat_b
);
    localparam logic [DW-1:0] BAND_LO = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] BAND_HI = BAND_LO + DW'(3);

    assert_band_sets_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld0 && data0 >= BAND_LO && data0 <= BAND_HI) |=> stat_a[1]);

    assert_xfer_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fcs_bad | link_fail)) |=> stat_a[2]);

    assert_sticky_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_sel) |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

    assert_sticky_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_sel) |=> ((stat_b & $past(stat_b)) == $past(stat_b)));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel && smp_valid == '0 && (fcs_bad | link_fail) == '0)
        |=> (stat_a == 8'h00));

    assert_alert_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> ((stat_a | stat_b) != 8'h00));
endmodule

bind cpu_temp_status cts_status_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld0      (smp_valid[0]),
    .data0     (smp_data[DW-1:0]),
    .fcs_bad   (fcs_bad),
    .link_fail (link_fail),
    .smp_valid (smp_valid),
    .host_rd   (host_rd),
    .host_sel  (host_sel),
    .alert_n   (alert_n),
    .stat_a    (stat_a),
    .stat_b    (stat_b)
);

// File: tb/cpu_temp_status_tb.sv
module cpu_temp_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    smp_valid;
    logic [NCH*DW-1:0] smp_data;
    logic [NCH-1:0]    fcs_bad, link_fail;
    logic              lim_we, lim_hi_sel, msk_we, msk_sel, host_rd, host_sel;
    logic [1:0]        lim_ch;
    logic [DW-1:0]     lim_wdata;
    logic [7:0]        msk_wdata, host_rdata;
    logic              alert_n;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [7:0]  m_a, m_b, m_ma, m_mb;
    logic [15:0] m_lo [NCH];
    logic [15:0] m_hi [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_temp_status u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .fcs_bad(fcs_bad), .link_fail(link_fail), .lim_we(lim_we), .lim_ch(lim_ch),
        .lim_hi_sel(lim_hi_sel), .lim_wdata(lim_wdata), .msk_we(msk_we),
        .msk_sel(msk_sel), .msk_wdata(msk_wdata), .host_rd(host_rd),
        .host_sel(host_sel), .host_rdata(host_rdata), .alert_n(alert_n)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic in_band(logic [15:0] d);
        return (d >= 16'h8000) && (d <= 16'h8003);
    endfunction

    function automatic logic exp_alert();
        return ((m_a & ~m_ma) | (m_b & ~m_mb)) == 8'h00;
    endfunction

    task automatic idle();
        smp_valid = '0; smp_data = '0; fcs_bad = '0; link_fail = '0;
        lim_we = 0; lim_ch = 0; lim_hi_sel = 0; lim_wdata = '0;
        msk_we = 0; msk_sel = 0; msk_wdata = '0; host_rd = 0; host_sel = 0;
    endtask

    // Apply the currently driven inputs for one edge, update model, check.
    task automatic tick(string req);
        logic [7:0] sa, sb;
        logic [15:0] d;
        sa = '0; sb = '0;
        for (int c = 0; c < NCH; c++) begin
            if (smp_valid[c]) begin
                d = smp_data[c*DW +: DW];
                if (in_band(d)) sa[1] = 1'b1;
                else if ($signed(d) > $signed(m_hi[c]) || $signed(d) < $signed(m_lo[c])) begin
                    if (c == 0) sa[0] = 1'b1;
                    else        sb[2 + c] = 1'b1;
                end
            end
        end
        if ((fcs_bad | link_fail) != '0) sa[2] = 1'b1;
        @(posedge clk);
        m_a = ((host_rd && !host_sel) ? 8'h00 : m_a) | sa;
        m_b = ((host_rd &&  host_sel) ? 8'h00 : m_b) | sb;
        if (msk_we) begin
            if (msk_sel) m_mb = msk_wdata; else m_ma = msk_wdata;
        end
        if (lim_we) begin
            if (lim_hi_sel) m_hi[lim_ch] = lim_wdata; else m_lo[lim_ch] = lim_wdata;
        end
        @(negedge clk);
        idle();
        #1 chk({req, " status A"}, 32'(host_rdata), 32'(m_a));
        host_sel = 1;
        #1 chk({req, " status B"}, 32'(host_rdata), 32'(m_b));
        host_sel = 0;
        chk({req, " alert_n"}, 32'(alert_n), 32'(exp_alert()));
    endtask

    task automatic sample(int c, logic [15:0] d);
        smp_valid[c] = 1'b1;
        smp_data[c*DW +: DW] = d;
    endtask

    task automatic set_lim(int c, logic hi, logic [15:0] v);
        lim_we = 1; lim_ch = 2'(c); lim_hi_sel = hi; lim_wdata = v;
    endtask

    task automatic read_clr(logic sel);
        host_rd = 1; host_sel = sel;
    endtask

    initial begin
        int unsigned seed;
        logic [15:0] v;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle();
        rst_n = 0;
        m_a = 0; m_b = 0; m_ma = 0; m_mb = 0;
        for (int c = 0; c < NCH; c++) begin m_lo[c] = 16'h8000; m_hi[c] = 16'h7fff; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1 chk("R1 reset status A", 32'(host_rdata), 0);
        chk("R1 reset alert_n", 32'(alert_n), 1);
        // R1: extreme readings cannot violate reset limits
        sample(0, 16'h7fff); sample(1, 16'h8004); tick("R1 reset limits");

        // R9 limits: ch0 window [-10, 50]; ch1 [0,100]; ch2 [-20,20]; ch3 [5,6]
        set_lim(0, 1, 16'd50); tick("R9 write");
        set_lim(0, 0, 16'hfff6); sample(0, 16'hfff7); tick("R9 old limit used");
        set_lim(1, 0, 16'd0); tick("R9 write");
        set_lim(1, 1, 16'd100); tick("R9 write");
        set_lim(2, 0, 16'hffec); tick("R9 write");
        set_lim(2, 1, 16'd20); tick("R9 write");
        set_lim(3, 0, 16'd5); tick("R9 write");
        set_lim(3, 1, 16'd6); tick("R9 write");

        sample(0, 16'd50); sample(0, 16'd50); tick("R6 equal high no violation");
        sample(0, 16'hfff6); tick("R6 equal low no violation");
        sample(0, 16'd51); tick("R4 ch0 above high");
        read_clr(0); tick("R7 read clears A");
        sample(2, 16'hffeb); tick("R5 ch2 below low (signed)");
        sample(1, 16'd101); sample(3, 16'd7); tick("R5 ch1 and ch3 high");
        read_clr(1); sample(3, 16'd4); tick("R7 set wins over clear");
        host_sel = 1; tick("R11 select without read");
        read_clr(1); tick("R7 read clears B");
        sample(0, 16'h8003); sample(1, 16'h8000); tick("R2 error band skips compare");
        read_clr(0); tick("R7 clear");
        sample(1, 16'h8004); tick("R2 0x8004 is temperature");
        smp_data[2*DW +: DW] = 16'h8000; tick("R10 data without valid");
        fcs_bad[3] = 1; tick("R3 fcs error");
        read_clr(0); tick("R7 clear");
        link_fail[1] = 1; tick("R3 link failure");
        msk_we = 1; msk_sel = 0; msk_wdata = 8'h04; tick("R8 mask A bit2");
        read_clr(1); tick("R8 clear B leaves masked A");
        msk_we = 1; msk_sel = 0; msk_wdata = 8'h00; tick("R8 unmask");
        read_clr(0); tick("R7 clear");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 2) == 0) begin
                    case ($urandom_range(0, 3))
                        0: v = 16'($urandom);
                        1: v = 16'h7ffe + 16'($urandom_range(0, 7));
                        2: v = m_hi[c] + 16'($urandom_range(0, 2)) - 16'd1;
                        default: v = m_lo[c] + 16'($urandom_range(0, 2)) - 16'd1;
                    endcase
                    sample(c, v);
                end
            end
            if ($urandom_range(0, 15) == 0) fcs_bad   = 4'($urandom);
            if ($urandom_range(0, 15) == 0) link_fail = 4'($urandom);
            if ($urandom_range(0, 3) == 0) read_clr(1'($urandom));
            if ($urandom_range(0, 19) == 0) begin
                v = 16'($urandom_range(0, 200)) - 16'd100;
                set_lim($urandom_range(0, 3), 1'($urandom), v);
            end
            if ($urandom_range(0, 31) == 0) begin
                msk_we = 1; msk_sel = 1'($urandom); msk_wdata = 8'($urandom);
            end
            tick("R6 random");
        end
        summary();
    end
endmodule